// File: doc/BRIEF.md
# Filtered Error Snapshot Register

This block smooths a stream of signed 16-bit motor error samples with a single-pole low-pass filter and makes the smoothed value readable by a processor over an 8-bit, read-only bus. A one-cycle sample strobe brings in each new error value at a fixed rate of about 16.5 kHz. The filter output moves one step toward the new input on each strobe. The step size gives a -3 dB corner of roughly 330 Hz at that rate.

The 16-bit result is split into a high byte at address 0xF3 and a low byte at address 0xF2. A processor reads one byte at a time, so a sample could arrive between the two reads. The block prevents that from mixing two samples. Reading the low byte takes a snapshot and holds both halves. Reading the high byte returns the snapshot's upper half and lets the visible value follow the filter again. Writes and reads of other addresses leave this state alone.

Top module: `ferr_snapshot`

## Requirements
- R1: While `rst_n` is low, the filter state, the snapshot, the lock flag and `rd_data` are all zero. Reset asserts asynchronously. Its release takes effect after two rising clock edges.
- R2: The filter keeps a 24-bit signed accumulator with 8 fractional bits. On each `smp_stb` it becomes acc + ((smp_val·256 − acc) >>> 3), saturated to 24-bit signed. The live value is acc >>> 8, which truncates toward minus infinity.
- R3: The live value changes only on a clock edge where `smp_stb` is high.
- R4: A read of 0xF2 while unlocked returns live[7:0]. It also captures the whole live value as the snapshot and sets the lock.
- R5: A read of 0xF3 while locked returns snapshot[15:8], however many samples have arrived since the lock. It also clears the lock.
- R6: While locked, the snapshot does not change. A further read of 0xF2 returns snapshot[7:0] and keeps the lock.
- R7: A read of 0xF3 while unlocked returns live[15:8] and leaves the block unlocked.
- R8: A bus cycle with `bus_we` high changes neither `rd_data` nor the lock state, at any address.
- R9: A read of any address other than 0xF2 or 0xF3 returns 0x00.
- R10: `rd_data` is registered. It is valid on the cycle after a read strobe and holds its value while `bus_stb` is low.
- R11: Full-scale inputs held for long runs drive the live value to the limit given by the R2 formula and never past the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe: `smp_val` holds a new error sample |
| smp_val | input | 16 | Signed motor error sample |
| bus_stb | input | 1 | Bus cycle strobe, one cycle per access |
| bus_we | input | 1 | 1 = write cycle (ignored), 0 = read cycle |
| bus_addr | input | 8 | Byte address |
| rd_data | output | 8 | Registered read data, valid the cycle after a read strobe |

## Verification
The hardest situation to reach is a lock that has lasted across several samples, so that the snapshot and the live value really differ. At that point a high-byte read must still return the old upper half.

The stimulus reaches it in steps:
- It first steps the input so the filter is still moving.
- It reads the low byte, then sends more samples that change both halves of the live value.
- It issues a write and a second low-byte read in the middle of the lock.
- It finally reads the high byte and compares against a bench-side model of the filter and the lock.

A high-byte read with no low read before it, followed by fresh samples and a low read, shows that the lock stayed clear.

// File: rtl/ferr_pkg.sv
package ferr_pkg;
  localparam int          BYTE_W      = 8;
  localparam logic [7:0]  ADDR_LO_DEF = 8'hF2;
  localparam logic [7:0]  ADDR_HI_DEF = 8'hF3;

  typedef enum logic [1:0] {
    SEL_IDLE,
    SEL_LO,
    SEL_HI,
    SEL_OTHER
  } sel_e;
endpackage

// File: rtl/ferr_lpf.sv
module ferr_lpf #(
  parameter int DW = 16,
  parameter int FW = 8,
  parameter int K  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] smp_val,
  output logic signed [DW-1:0] live
);
  localparam int ACC_W = DW + FW;
  localparam logic signed [ACC_W+1:0] SAT_HI = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W+1:0] SAT_LO = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;
  logic signed [ACC_W+1:0] sum;

  always_comb begin
    x_ext = {smp_val, {FW{1'b0}}};
    diff  = {x_ext[ACC_W-1], x_ext} - {acc_q[ACC_W-1], acc_q};
    step  = diff >>> K;
    sum   = {{2{acc_q[ACC_W-1]}}, acc_q} + {step[ACC_W], step};
    acc_d = acc_q;
    if (smp_stb) begin
      if (sum > SAT_HI)      acc_d = SAT_HI[ACC_W-1:0];
      else if (sum < SAT_LO) acc_d = SAT_LO[ACC_W-1:0];
      else                   acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign live = acc_q[ACC_W-1:FW];
endmodule

// File: rtl/ferr_hold.sv
module ferr_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic [DW-1:0] live,
  output logic [DW-1:0] snap,
  output logic          locked,
  output logic [DW-1:0] view
);
  logic [DW-1:0] snap_d;
  logic          lock_d;

  always_comb begin
    snap_d = locked ? snap : live;
    lock_d = locked;
    if (rd_lo)      lock_d = 1'b1;
    else if (rd_hi) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      locked <= 1'b0;
    end else begin
      snap   <= snap_d;
      locked <= lock_d;
    end
  end

  assign view = locked ? snap : live;
endmodule

// File: rtl/ferr_rdport.sv
module ferr_rdport
  import ferr_pkg::*;
#(
  parameter int         DW      = 16,
  parameter int         AW      = 8,
  parameter logic [7:0] ADDR_LO = ADDR_LO_DEF,
  parameter logic [7:0] ADDR_HI = ADDR_HI_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     view,
  output logic              rd_lo,
  output logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data
);
  sel_e              sel;
  logic [BYTE_W-1:0] rd_d;

  always_comb begin
    sel = SEL_IDLE;
    if (bus_stb && !bus_we) begin
      if (bus_addr == AW'(ADDR_LO))      sel = SEL_LO;
      else if (bus_addr == AW'(ADDR_HI)) sel = SEL_HI;
      else                               sel = SEL_OTHER;
    end
    rd_lo = (sel == SEL_LO);
    rd_hi = (sel == SEL_HI);
    rd_d  = rd_data;
    case (sel)
      SEL_LO:    rd_d = view[BYTE_W-1:0];
      SEL_HI:    rd_d = view[2*BYTE_W-1:BYTE_W];
      SEL_OTHER: rd_d = '0;
      default:   rd_d = rd_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/ferr_snapshot.sv
module ferr_snapshot
  import ferr_pkg::*;
#(
  parameter int         DW      = 16,
  parameter int         FW      = 8,
  parameter int         K       = 3,
  parameter int         AW      = 8,
  parameter logic [7:0] ADDR_LO = ADDR_LO_DEF,
  parameter logic [7:0] ADDR_HI = ADDR_HI_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] smp_val,
  input  logic                 bus_stb,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  output logic [BYTE_W-1:0]    rd_data
);
  logic          rst_meta, rst_sync_n;
  logic [DW-1:0] live, snap, view;
  logic          locked, rd_lo, rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ferr_lpf #(.DW(DW), .FW(FW), .K(K)) u_lpf (
    .clk(clk), .rst_n(rst_sync_n), .smp_stb(smp_stb), .smp_val(smp_val), .live(live)
  );

  ferr_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .live(live), .snap(snap), .locked(locked), .view(view)
  );

  ferr_rdport #(.DW(DW), .AW(AW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .view(view), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
  );
endmodule

// File: rtl/ferr_snapshot_chk.sv
module ferr_snapshot_chk #(
  parameter int         DW      = 16,
  parameter int         AW      = 8,
  parameter logic [7:0] ADDR_LO = 8'hF2,
  parameter logic [7:0] ADDR_HI = 8'hF3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic          bus_stb,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    rd_data,
  input logic          locked,
  input logic [DW-1:0] snap,
  input logic [DW-1:0] live
);
  logic rd_cyc, is_lo, is_hi;
  assign rd_cyc = bus_stb && !bus_we;
  assign is_lo  = rd_cyc && (bus_addr == AW'(ADDR_LO));
  assign is_hi  = rd_cyc && (bus_addr == AW'(ADDR_HI));

  p_filter_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(live));

  p_lock_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_lo |=> locked);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_hi |=> !locked);

  p_snap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(snap));

  p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && bus_we) |=> ($stable(rd_data) && $stable(locked)));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && !is_lo && !is_hi) |=> (rd_data == 8'h00));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_stb |=> $stable(rd_data));
endmodule

bind ferr_snapshot ferr_snapshot_chk #(
  .DW(DW), .AW(AW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .smp_stb(smp_stb), .bus_stb(bus_stb),
  .bus_we(bus_we), .bus_addr(bus_addr), .rd_data(rd_data),
  .locked(locked), .snap(snap), .live(live)
);

// File: tb/sim_ferr_snapshot.sv
module sim_ferr_snapshot;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // each entry: [23:8] sample value, [7:0] number of strobes
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h4000, 8'd1}, {16'h4000, 8'd3}, {16'h0000, 8'd2}, {16'hC000, 8'd4},
    {16'h1234, 8'd5}, {16'h7FFF, 8'd1}, {16'h8000, 8'd2}, {16'h00FF, 8'd6},
    {16'hFF01, 8'd3}, {16'h2A5C, 8'd8}, {16'hD3A7, 8'd2}, {16'h0100, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic [15:0] smp_val = '0;
  logic        bus_stb = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;

  longint      m_acc = 0;
  logic        m_lock = 1'b0;
  logic [15:0] m_snap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ferr_snapshot u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_val(smp_val),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] m_live();
    longint v;
    v = m_acc >>> 8;
    return v[15:0];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sample(input logic [15:0] v);
    longint x;
    @(negedge clk);
    smp_stb = 1'b1;
    smp_val = v;
    @(negedge clk);
    smp_stb = 1'b0;
    x = longint'($signed(v));
    m_acc = m_acc + (((x * 256) - m_acc) >>> 3);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_stb = 1'b1;
    bus_we = 1'b0;
    bus_addr = a;
    @(negedge clk);
    bus_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic bus_write(input logic [7:0] a);
    @(negedge clk);
    bus_stb = 1'b1;
    bus_we = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_stb = 1'b0;
    bus_we = 1'b0;
  endtask

  task automatic read_lo(input string req);
    logic [7:0] d, e;
    logic [15:0] lv;
    lv = m_live();
    e = m_lock ? m_snap[7:0] : lv[7:0];
    if (!m_lock) begin
      m_snap = lv;
      m_lock = 1'b1;
    end
    bus_read(8'hF2, d);
    chk(req, d, e);
  endtask

  task automatic read_hi(input string req);
    logic [7:0] d, e;
    logic [15:0] lv;
    lv = m_live();
    e = m_lock ? m_snap[15:8] : lv[15:8];
    m_lock = 1'b0;
    bus_read(8'hF3, d);
    chk(req, d, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_acc = 0;
    m_lock = 1'b0;
    m_snap = '0;
    @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, keep;
    repeat (3) @(negedge clk);
    chk("R1 rd_data during reset", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_lo("R1 lo after reset");
    read_hi("R1 hi after reset");

    // table walk: R2 filter arithmetic, R4/R5 paired reads
    for (int i = 0; i < NVEC; i++) begin
      for (int j = 0; j < int'(VEC[i][7:0]); j++) sample(VEC[i][23:8]);
      read_lo("R2 R4 table lo");
      read_hi("R2 R5 table hi");
    end

    // R3: no strobe, value holds over idle cycles
    repeat (5) @(negedge clk);
    read_lo("R3 lo after idle");
    repeat (4) @(negedge clk);
    read_hi("R3 hi after idle");

    // R4 R5 R6 R8: long lock across moving samples
    do_reset();
    sample(16'h0100);
    read_lo("R4 lock lo");
    for (int j = 0; j < 6; j++) sample(16'h7000);
    read_lo("R6 second lo while locked");
    keep = rd_data;
    bus_write(8'hF3);
    chk("R8 rd_data after write", rd_data, keep);
    bus_write(8'hF2);
    sample(16'h6000);
    read_hi("R5 hi returns snapshot");
    sample(16'h6000);
    read_lo("R5 unlocked lo tracks live");
    read_hi("R5 hi pairs with lo");

    // R7: high read without low read
    sample(16'hA000);
    read_hi("R7 hi while unlocked");
    sample(16'h1000);
    read_lo("R7 lo still unlocked");
    read_hi("R7 pair hi");

    // R8: write while unlocked does not lock
    bus_write(8'hF2);
    sample(16'h5555);
    read_hi("R8 write did not lock");

    // R9: unmapped addresses
    bus_read(8'hF1, d);
    chk("R9 addr F1", d, 8'h00);
    bus_read(8'h00, d);
    chk("R9 addr 00", d, 8'h00);
    bus_read(8'hFF, d);
    chk("R9 addr FF", d, 8'h00);

    // R10: registered data holds while idle
    read_hi("R10 hi read");
    keep = rd_data;
    repeat (4) @(negedge clk);
    chk("R10 hold while idle", rd_data, keep);

    // R11: full-scale saturation
    for (int j = 0; j < 200; j++) sample(16'h7FFF);
    read_lo("R11 pos lo");
    read_hi("R11 pos hi");
    for (int j = 0; j < 200; j++) sample(16'h8000);
    read_lo("R11 neg lo");
    read_hi("R11 neg hi");

    // R1: reset mid-lock clears everything
    sample(16'h3333);
    read_lo("R1 pre-reset lo");
    do_reset();
    read_hi("R1 hi after mid-lock reset");
    sample(16'h4444);
    read_lo("R1 unlocked after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule